// File: doc/BRIEF.md
# Comma-Aligned Receive Framer

This block sits directly behind a serial deserializer front end. It takes one line bit per bit clock, where each character is ten bits long, and recovers the character boundaries. It searches a ten-bit sliding window for the seven-bit comma head of the K28.5 control character, in either running disparity. When it accepts a comma, it moves the boundary so that the character holding the comma is presented as a whole word. Aligned words leave the block on a parallel bus, marked by a single-cycle valid strobe, once every ten bit clocks.

A reframe-enable input decides whether commas may move the boundary. With it low, the boundary comes only from a free-running ten-bit phase counter, so a bit error that forges a comma cannot shift the framing. With it high, a lone comma realigns the stream at once. After 2,048 consecutive words with reframing enabled, the framer becomes stricter: it then needs two commas back to back on the same new alignment before it moves. Dropping reframe-enable clears this count and returns the framer to the single-comma rule. A sticky framed indicator shows that at least one comma has been accepted since reset.

Top module: `comma_framer`

## Requirements
- R1: With reframeEn high, in single-comma mode, a comma that completes off the current boundary moves the boundary. The ten bits that hold the comma appear on wordOut with wordValid high in the cycle after the comma's last bit is sampled. Later words follow every ten bit clocks.
- R2: The bit sampled first lands in wordOut[9]. A comma is a window whose first seven received bits (wordOut[9:3]) are 0011111 or 1100000. Both polarities are accepted.
- R3: When no realignment happens, wordValid pulses exactly once every ten bit clocks, starting from reset and independent of reframeEn.
- R4: While reframeEn is low, no comma moves the boundary, and the ten-clock spacing of wordValid is kept.
- R5: framed is low after reset. It goes high when a comma is accepted with reframeEn high and stays high until the next reset, even when reframeEn is low.
- R6: After 2,048 consecutive words with reframeEn high, the framer enters double-comma mode. In that mode a single comma off the boundary does not move it.
- R7: In double-comma mode, two commas back to back (exactly ten bits apart) off the current boundary move it. The second comma is presented as the realigned word.
- R8: A low level on reframeEn clears the consecutive-word count and leaves double-comma mode, so that after reframeEn returns high a single comma realigns again.
- R9: While rstN is low, wordValid, framed and wordOut are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial line bit, one per clock |
| reframeEn | input | 1 | High allows commas to move the word boundary |
| wordOut | output | 10 | Aligned character, first received bit in bit 9 |
| wordValid | output | 1 | One-cycle strobe that marks a new wordOut |
| framed | output | 1 | Sticky flag: a comma has been accepted since reset |

## Verification
Double-comma mode is the hardest state to reach from the ports. It needs more than two thousand aligned words with reframeEn held high, followed by commas placed at a chosen offset from a boundary the bench must already know. The bench first realigns on a single comma so that it knows the boundary exactly. It then streams 2,100 comma-free alternating filler words and inserts first a lone comma, then a back-to-back pair, each at an offset a few bits off the boundary. Between these it pads with filler bits so that the bench's notion of the boundary stays in step with the design.

// File: rtl/framer_pkg.sv
package framer_pkg;
  // Strobe bundle sent from the control side to the datapath.
  typedef struct packed {
    logic loadWord;   // capture the current window as an aligned word
  } frame_strobe_t;
endpackage

// File: rtl/framer_datapath.sv
module framer_datapath
  import framer_pkg::*;
#(
  parameter int WORD_BITS = 10,
  parameter int COMMA_BITS = 7,
  parameter logic [COMMA_BITS-1:0] COMMA_PAT = 7'b0011111
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  frame_strobe_t        strobe,
  output logic                 commaHit,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordValid
);
  localparam int POLARITIES = 2;

  logic [WORD_BITS-1:0]  shiftReg;
  logic [COMMA_BITS-1:0] windowHead;
  logic [POLARITIES-1:0] polHit;

  // Oldest bit sits at the top of the window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[WORD_BITS-2:0], serIn};
  end

  assign windowHead = shiftReg[WORD_BITS-1 -: COMMA_BITS];

  // One comparator per running-disparity polarity of the comma head.
  for (genvar g = 0; g < POLARITIES; g++) begin : g_pol
    localparam logic [COMMA_BITS-1:0] PAT = (g == 0) ? COMMA_PAT : ~COMMA_PAT;
    assign polHit[g] = (windowHead == PAT);
  end

  assign commaHit = |polHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strobe.loadWord;
      if (strobe.loadWord) wordOut <= shiftReg;
    end
  end
endmodule

// File: rtl/framer_control.sv
module framer_control
  import framer_pkg::*;
#(
  parameter int WORD_BITS = 10,
  parameter int STABLE_BYTES = 2048
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reframeEn,
  input  logic          commaHit,
  output frame_strobe_t strobe,
  output logic          framed,
  output logic          dblMode
);
  localparam int PH_W = $clog2(WORD_BITS);
  localparam int ST_W = $clog2(STABLE_BYTES + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_BITS - 1);
  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STABLE_BYTES - 1);

  // phase == 0 means the window currently holds an aligned word.
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] candPhase;
  logic            candPend;
  logic [ST_W-1:0] stableCnt;

  logic atBoundary, offHit, candHit, realign, loadWord;

  function automatic logic [PH_W-1:0] stepPhase(input logic [PH_W-1:0] p);
    return (p == PH_LAST) ? '0 : p + PH_ONE;
  endfunction

  always_comb begin
    atBoundary = (phase == '0);
    offHit     = reframeEn && commaHit && !atBoundary;
    candHit    = candPend && (candPhase == '0);
    realign    = offHit && (!dblMode || candHit);
    loadWord   = atBoundary || realign;
  end

  assign strobe.loadWord = loadWord;

  // Word phase counter, reloaded when a comma moves the boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        phase <= PH_ONE;
    else if (realign) phase <= PH_ONE;
    else              phase <= stepPhase(phase);
  end

  // Candidate tracker for double-comma mode: one pending alignment.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candPend  <= 1'b0;
      candPhase <= '0;
    end else if (!reframeEn || !dblMode || realign) begin
      candPend  <= 1'b0;
      candPhase <= stepPhase(candPhase);
    end else if (offHit) begin
      candPend  <= 1'b1;
      candPhase <= PH_ONE;
    end else begin
      if (candHit) candPend <= 1'b0;
      candPhase <= stepPhase(candPhase);
    end
  end

  // Consecutive-word count with reframing enabled; selects double mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableCnt <= '0;
      dblMode   <= 1'b0;
    end else if (!reframeEn) begin
      stableCnt <= '0;
      dblMode   <= 1'b0;
    end else if (loadWord && !dblMode) begin
      stableCnt <= stableCnt + 1'b1;
      if (stableCnt == ST_LAST) dblMode <= 1'b1;
    end
  end

  // Sticky framed flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) framed <= 1'b0;
    else if (reframeEn && commaHit && (atBoundary || realign)) framed <= 1'b1;
  end
endmodule

// File: rtl/comma_framer.sv
module comma_framer
  import framer_pkg::*;
#(
  parameter int WORD_BITS = 10,
  parameter int COMMA_BITS = 7,
  parameter int STABLE_BYTES = 2048,
  parameter logic [COMMA_BITS-1:0] COMMA_PAT = 7'b0011111
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  logic                 reframeEn,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordValid,
  output logic                 framed
);
  frame_strobe_t strobe;
  logic          commaHit;
  logic          dblMode;

  framer_control #(
    .WORD_BITS(WORD_BITS),
    .STABLE_BYTES(STABLE_BYTES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .reframeEn(reframeEn),
    .commaHit(commaHit),
    .strobe(strobe),
    .framed(framed),
    .dblMode(dblMode)
  );

  framer_datapath #(
    .WORD_BITS(WORD_BITS),
    .COMMA_BITS(COMMA_BITS),
    .COMMA_PAT(COMMA_PAT)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .serIn(serIn),
    .strobe(strobe),
    .commaHit(commaHit),
    .wordOut(wordOut),
    .wordValid(wordValid)
  );
endmodule

// File: rtl/framer_checker.sv
module framer_checker #(
  parameter int WORD_BITS = 10,
  parameter int COMMA_BITS = 7,
  parameter logic [COMMA_BITS-1:0] COMMA_PAT = 7'b0011111
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reframeEn,
  input logic [WORD_BITS-1:0] wordOut,
  input logic                 wordValid,
  input logic                 framed,
  input logic                 dblMode
);
  logic [7:0] gap;
  logic       seen;
  logic       shortGap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (wordValid) begin
      gap  <= 8'd1;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 8'd1;
    end
  end

  assign shortGap = wordValid && seen && (gap != 8'(WORD_BITS));

  // R4: an off-rhythm word can only follow a cycle with reframing enabled.
  assert_no_move_when_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    shortGap |-> $past(reframeEn));

  // R1 / R2: an off-rhythm word always carries a comma head.
  assert_realign_on_comma_R1: assert property (@(posedge clk) disable iff (!rstN)
    shortGap |-> (wordOut[WORD_BITS-1 -: COMMA_BITS] == COMMA_PAT ||
                  wordOut[WORD_BITS-1 -: COMMA_BITS] == ~COMMA_PAT));

  // R5: framed never drops outside reset.
  assert_framed_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    framed |=> framed);

  // R8: reframing disabled leaves double mode on the next cycle.
  assert_dbl_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reframeEn |=> !dblMode);

  // R6: double mode is entered only while reframing is enabled.
  assert_dbl_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dblMode) |-> $past(reframeEn));
endmodule

bind comma_framer framer_checker #(
  .WORD_BITS(WORD_BITS),
  .COMMA_BITS(COMMA_BITS),
  .COMMA_PAT(COMMA_PAT)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .reframeEn(reframeEn),
  .wordOut(wordOut),
  .wordValid(wordValid),
  .framed(framed),
  .dblMode(dblMode)
);

// File: tb/comma_framer_tb.sv
`timescale 1ns/1ps
module comma_framer_tb;
  localparam logic [9:0] COMMA_N = 10'b0011111010;
  localparam logic [9:0] COMMA_P = 10'b1100000101;
  localparam logic [9:0] FILL    = 10'b1010101010;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serIn = 1'b0;
  logic       reframeEn = 1'b0;
  logic [9:0] wordOut;
  logic       wordValid;
  logic       framed;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int lastStamp = 0;
  int prevStamp = 0;
  logic [9:0] capW[$];
  int         capT[$];

  always #4 clk = ~clk;

  comma_framer u_dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .reframeEn(reframeEn),
    .wordOut(wordOut), .wordValid(wordValid), .framed(framed)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && wordValid) begin
      capW.push_back(wordOut);
      capT.push_back(cyc);
      lastStamp = cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    serIn = b;
  endtask

  task automatic sendWord(input logic [9:0] w);
    for (int i = 9; i >= 0; i--) sendBit(w[i]);
  endtask

  // First n bits of the filler pattern.
  task automatic sendPart(input int n);
    for (int i = 0; i < n; i++) sendBit(FILL[9-i]);
  endtask

  task automatic sendFills(input int n);
    for (int i = 0; i < n; i++) sendWord(FILL);
  endtask

  task automatic startCapture();
    @(posedge clk);
    prevStamp = lastStamp;
    capW.delete();
    capT.delete();
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic checkMoved(input string tag, input logic [9:0] cw);
    int idx = -1;
    int tail;
    bit allFill = 1'b1;
    bit spaced = 1'b1;
    foreach (capW[i]) if (idx < 0 && capW[i] == cw) idx = i;
    check(idx >= 0, {tag, " comma word presented"}, idx, 0);
    if (idx >= 0) begin
      tail = capW.size() - idx - 1;
      for (int i = idx + 1; i < capW.size(); i++) begin
        if (capW[i] != FILL) allFill = 1'b0;
        if (capT[i] - capT[i-1] != 10) spaced = 1'b0;
      end
      check(tail >= 3, {tag, " words after realign"}, tail, 3);
      check(allFill, {tag, " aligned filler after comma"}, allFill, 1);
      check(spaced, {tag, " ten-clock spacing after realign"}, spaced, 1);
    end
  endtask

  task automatic checkStill(input string tag, input logic [9:0] cw);
    bit noComma = 1'b1;
    bit spaced = 1'b1;
    int last = prevStamp;
    foreach (capW[i]) begin
      if (capW[i] == cw) noComma = 1'b0;
      if (capT[i] - last != 10) spaced = 1'b0;
      last = capT[i];
    end
    check(noComma, {tag, " boundary not moved"}, noComma, 1);
    check(spaced, {tag, " ten-clock spacing kept"}, spaced, 1);
  endtask

  task automatic testReset();
    repeat (5) @(negedge clk);
    check(wordValid == 1'b0, "R9 wordValid in reset", wordValid, 0);
    check(framed == 1'b0, "R9 framed in reset", framed, 0);
    check(wordOut == 10'd0, "R9 wordOut in reset", wordOut, 0);
    rstN = 1'b1;
  endtask

  task automatic testFreeRun();
    int last;
    bit spaced = 1'b1;
    startCapture();
    sendFills(8);
    settle();
    check(capW.size() >= 7, "R3 free-running word count", capW.size(), 7);
    last = capT[0];
    for (int i = 1; i < capT.size(); i++) begin
      if (capT[i] - last != 10) spaced = 1'b0;
      last = capT[i];
    end
    check(spaced, "R3 ten-clock word spacing", spaced, 1);
    check(framed == 1'b0, "R5 framed low before any comma", framed, 0);
  endtask

  task automatic testSingleNeg();
    @(negedge clk) reframeEn = 1'b1;
    startCapture();
    sendPart(3);
    sendWord(COMMA_N);
    sendFills(5);
    settle();
    checkMoved("R1", COMMA_N);
    check(framed == 1'b1, "R5 framed after accepted comma", framed, 1);
  endtask

  task automatic testSinglePos();
    startCapture();
    sendPart(6);
    sendWord(COMMA_P);
    sendFills(5);
    settle();
    checkMoved("R2 other polarity", COMMA_P);
  endtask

  task automatic testReframeOff();
    @(negedge clk) reframeEn = 1'b0;
    startCapture();
    sendPart(4);
    sendWord(COMMA_N);
    sendFills(4);
    sendPart(6);
    sendFills(2);
    settle();
    checkStill("R4", COMMA_N);
    check(framed == 1'b1, "R5 framed sticky with reframing off", framed, 1);
  endtask

  task automatic testDoubleSingle();
    @(negedge clk) reframeEn = 1'b1;
    sendFills(2100);
    startCapture();
    sendPart(5);
    sendWord(COMMA_N);
    sendFills(4);
    sendPart(5);
    sendFills(2);
    settle();
    checkStill("R6 lone comma in double mode", COMMA_N);
  endtask

  task automatic testDoublePair();
    startCapture();
    sendPart(2);
    sendWord(COMMA_N);
    sendWord(COMMA_N);
    sendFills(5);
    settle();
    checkMoved("R7 comma pair", COMMA_N);
  endtask

  task automatic testRestart();
    @(negedge clk) reframeEn = 1'b0;
    sendFills(3);
    @(negedge clk) reframeEn = 1'b1;
    sendPart(9);
    sendFills(2);
    startCapture();
    sendPart(7);
    sendWord(COMMA_N);
    sendFills(5);
    settle();
    checkMoved("R8 single comma after restart", COMMA_N);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    testReset();
    testFreeRun();
    testSingleNeg();
    testSinglePos();
    testReframeOff();
    testDoubleSingle();
    testDoublePair();
    testRestart();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule